// File: doc/BRIEF.md
# Speculative Indirect-Branch Label Checker

This unit sits in the decode stage and watches the in-order stream of decoded instructions. Each instruction arrives with a class code and a label. When an indirect call or indirect jump is decoded, the unit stores that branch's label and arms a wait. The next decoded instruction must be a label-marker that carries the same label. If it is, the unit pulses a check-passed strobe, and speculation goes on with no stall.

If the next instruction is any other class, or is a marker with a different label, the unit pulses a fence-request strobe. The pipeline answers that strobe by inserting one load-fence micro-op, so execution cannot run ahead down a path it was steered onto illegally. Because the check runs on the speculative path at decode, it limits speculation before retirement.

Cycles with the decode-valid input low do not count as instructions, so bubbles between a branch and its target are ignored. A pipeline flush drops any pending wait.

Top module: `spec_label_guard`

## Requirements
- R1: After the asynchronous reset is released, the unit is idle and both `fence_req` and `check_ok` are low.
- R2: A valid instruction with class 2'b01 (indirect call or jump) stores its label and arms the wait. The stored label is the one that a later marker is compared against.
- R3: While armed, a valid class 2'b10 (label-marker) instruction whose 32-bit label equals the stored label raises `check_ok` for exactly one cycle. That pulse is visible on the clock edge after the instruction is presented, and the unit returns to idle.
- R4: While armed, a label-marker whose label differs from the stored label raises `fence_req` for exactly one cycle, and the unit returns to idle.
- R5: While armed, a valid class 2'b00 instruction (other) raises `fence_req` for one cycle, and the unit returns to idle.
- R6: A label-marker decoded while idle is a no-op. It raises no strobe and does not arm the wait.
- R7: Cycles with `dec_valid` low change no state and raise no strobe, however many of them come between a branch and its target.
- R8: `flush` returns the unit to idle and clears a pending wait. A valid instruction presented in the same cycle as `flush` is discarded and raises no strobe.
- R9: While armed, a further indirect branch raises `fence_req` for one cycle and re-arms the wait with its own label.
- R10: `fence_req` and `check_ok` are never high in the same cycle. The label comparison covers all 32 bits, so labels that differ only in bit 31 or only in bit 0 do not match.
- R11: Class code 2'b11 is treated as "other": while armed it is a violation, and while idle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Pipeline flush; clears any pending wait |
| dec_valid | input | 1 | High when a decoded instruction is presented |
| dec_class | input | 2 | 00 other, 01 indirect call/jump, 10 label-marker, 11 other |
| dec_label | input | 32 | Label field of the decoded instruction |
| fence_req | output | 1 | One-cycle request to insert one load-fence micro-op |
| check_ok | output | 1 | One-cycle strobe: the branch target carried a matching label |

## Verification
Both strobes are registered. The result for an instruction presented in one cycle appears on the outputs one clock edge later, and it lasts for that one cycle only. The bench changes inputs on the falling edge and reads the outputs on the following falling edge. At that point the strobe that belongs to the instruction just accepted is stable, and the strobe of the next instruction has not yet been captured. Checks for ignored stimulus (idle markers, bubbles, flush) read both strobes in that same slot. They then send a probe marker or branch to show that the internal wait was or was not changed.

// File: rtl/spec_label_guard_pkg.sv
package spec_label_guard_pkg;

  localparam int unsigned CLASS_W = 2;

  typedef enum logic [CLASS_W-1:0] {
    CLS_OTHER  = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_MARKER = 2'b10,
    CLS_RSVD   = 2'b11
  } insn_class_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } guard_state_e;

  typedef struct packed {
    logic is_branch;
    logic is_marker;
    logic is_other;
  } insn_kind_t;

endpackage

// File: rtl/spec_label_guard_classify.sv
module spec_label_guard_classify
  import spec_label_guard_pkg::*;
(
  input  logic               valid_i,
  input  logic               flush_i,
  input  logic [CLASS_W-1:0] class_i,
  output insn_kind_t         kind_o
);

  logic accept;

  always_comb begin
    accept = valid_i & ~flush_i;
    kind_o = '0;
    if (accept) begin
      unique case (class_i)
        CLS_BRANCH: kind_o.is_branch = 1'b1;
        CLS_MARKER: kind_o.is_marker = 1'b1;
        default:    kind_o.is_other  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/spec_label_guard_store.sv
module spec_label_guard_store #(
  parameter int unsigned LABEL_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [LABEL_W-1:0] label_i,
  input  logic [LABEL_W-1:0] cmp_label_i,
  output logic               match_o
);

  logic [LABEL_W-1:0] label_q;
  logic [LABEL_W-1:0] label_d;
  logic [LABEL_W-1:0] diff;

  always_comb begin
    label_d = label_q;
    if (load_en) label_d = label_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) label_q <= '0;
    else        label_q <= label_d;
  end

  // The compare is built bit by bit and then reduced, over the full width.
  for (genvar b = 0; b < LABEL_W; b++) begin : g_bit
    assign diff[b] = label_q[b] ^ cmp_label_i[b];
  end

  assign match_o = ~|diff;

endmodule

// File: rtl/spec_label_guard_fsm.sv
module spec_label_guard_fsm
  import spec_label_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_i,
  input  insn_kind_t kind_i,
  input  logic       match_i,
  output logic       load_o,
  output logic       armed_o,
  output logic       fence_o,
  output logic       pass_o
);

  guard_state_e state_q, state_d;
  logic         fence_d, pass_d;
  logic         fence_q, pass_q;

  always_comb begin
    state_d = state_q;
    fence_d = 1'b0;
    pass_d  = 1'b0;
    load_o  = 1'b0;
    if (flush_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (kind_i.is_branch) begin
            load_o  = 1'b1;
            state_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (kind_i.is_branch) begin
            fence_d = 1'b1;
            load_o  = 1'b1;
            state_d = ST_WAIT;
          end else if (kind_i.is_marker) begin
            fence_d = ~match_i;
            pass_d  = match_i;
            state_d = ST_IDLE;
          end else if (kind_i.is_other) begin
            fence_d = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fence_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fence_q <= fence_d;
      pass_q  <= pass_d;
    end
  end

  assign armed_o = (state_q == ST_WAIT);
  assign fence_o = fence_q;
  assign pass_o  = pass_q;

endmodule

// File: rtl/spec_label_guard.sv
module spec_label_guard
  import spec_label_guard_pkg::*;
#(
  parameter int unsigned LABEL_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               dec_valid,
  input  logic [CLASS_W-1:0] dec_class,
  input  logic [LABEL_W-1:0] dec_label,
  output logic               fence_req,
  output logic               check_ok
);

  insn_kind_t kind;
  logic       load_en;
  logic       label_match;
  logic       armed;

  spec_label_guard_classify u_classify (
    .valid_i (dec_valid),
    .flush_i (flush),
    .class_i (dec_class),
    .kind_o  (kind)
  );

  spec_label_guard_store #(.LABEL_W(LABEL_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .label_i     (dec_label),
    .cmp_label_i (dec_label),
    .match_o     (label_match)
  );

  spec_label_guard_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush),
    .kind_i  (kind),
    .match_i (label_match),
    .load_o  (load_en),
    .armed_o (armed),
    .fence_o (fence_req),
    .pass_o  (check_ok)
  );

endmodule

// File: rtl/spec_label_guard_checker.sv
module spec_label_guard_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       dec_valid,
  input logic [1:0] dec_class,
  input logic       armed,
  input logic       fence_req,
  input logic       check_ok
);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fence_req && check_ok));

  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!fence_req && !check_ok && !armed));

  a_r7_bubble_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid && !flush) |=> (!fence_req && !check_ok && $stable(armed)));

  a_r6_idle_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && dec_valid && !flush && dec_class == 2'b10)
      |=> (!fence_req && !check_ok && !armed));

  a_r5_other_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dec_valid && !flush && !dec_class[1] && !dec_class[0])
      |=> (fence_req && !armed));

  a_r11_rsvd_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dec_valid && !flush && dec_class == 2'b11) |=> fence_req);

  a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dec_valid && !flush && dec_class == 2'b01) |=> (fence_req && armed));

  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && dec_valid && !flush && dec_class == 2'b01) |=> armed);

  a_r3_pass_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(check_ok) |-> $past(armed));

endmodule

bind spec_label_guard spec_label_guard_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .dec_valid (dec_valid),
  .dec_class (dec_class),
  .armed     (armed),
  .fence_req (fence_req),
  .check_ok  (check_ok)
);

// File: tb/spec_label_guard_tb.sv
`timescale 1ns/1ps
module spec_label_guard_tb_top;

  localparam logic [1:0] C_OTHER  = 2'b00;
  localparam logic [1:0] C_BRANCH = 2'b01;
  localparam logic [1:0] C_MARKER = 2'b10;
  localparam logic [1:0] C_RSVD   = 2'b11;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        dec_valid;
  logic [1:0]  dec_class;
  logic [31:0] dec_label;
  logic        fence_req;
  logic        check_ok;

  int checks;
  int errors;
  bit done;

  spec_label_guard dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .dec_label (dec_label),
    .fence_req (fence_req),
    .check_ok  (check_ok)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic expect_out(input string req, input logic exp_f, input logic exp_ok);
    checks++;
    if (fence_req !== exp_f || check_ok !== exp_ok) begin
      errors++;
      $display("FAIL %s: fence_req=%b check_ok=%b expected fence_req=%b check_ok=%b",
               req, fence_req, check_ok, exp_f, exp_ok);
    end
  endtask

  // Present one cycle of input on the falling edge; outputs for it are read at the next falling edge.
  task automatic step(input logic v, input logic [1:0] c, input logic [31:0] l, input logic f);
    dec_valid = v;
    dec_class = c;
    dec_label = l;
    flush     = f;
    @(negedge clk);
    dec_valid = 1'b0;
    flush     = 1'b0;
  endtask

  task automatic t_reset;
    expect_out("R1", 1'b0, 1'b0);
  endtask

  task automatic t_match;
    step(1, C_BRANCH, 32'hA5A5_0001, 0); expect_out("R2", 0, 0);
    step(1, C_MARKER, 32'hA5A5_0001, 0); expect_out("R3", 0, 1);
    step(0, C_OTHER, 0, 0);              expect_out("R3 pulse width", 0, 0);
  endtask

  task automatic t_mismatch;
    step(1, C_BRANCH, 32'h1234_5678, 0);
    step(1, C_MARKER, 32'h1234_5679, 0); expect_out("R4", 1, 0);
    step(1, C_MARKER, 32'h1234_5678, 0); expect_out("R4 back to idle", 0, 0);
    step(1, C_BRANCH, 32'h0000_0007, 0);
    step(1, C_MARKER, 32'h8000_0007, 0); expect_out("R10 bit31", 1, 0);
    step(1, C_BRANCH, 32'hFFFF_FFFF, 0);
    step(1, C_MARKER, 32'hFFFF_FFFE, 0); expect_out("R10 bit0", 1, 0);
  endtask

  task automatic t_other;
    step(1, C_BRANCH, 32'hDEAD_BEEF, 0);
    step(1, C_OTHER, 32'hDEAD_BEEF, 0);  expect_out("R5", 1, 0);
    step(1, C_MARKER, 32'hDEAD_BEEF, 0); expect_out("R5 idle after", 0, 0);
    step(1, C_BRANCH, 32'h0000_0042, 0);
    step(1, C_RSVD, 32'h0000_0042, 0);   expect_out("R11 armed", 1, 0);
    step(1, C_RSVD, 32'h0000_0042, 0);   expect_out("R11 idle", 0, 0);
    step(1, C_MARKER, 32'h0000_0042, 0); expect_out("R11 not armed", 0, 0);
  endtask

  task automatic t_idle_marker;
    step(1, C_MARKER, 32'h0000_0000, 0); expect_out("R6", 0, 0);
    step(1, C_OTHER, 32'h0000_0000, 0);  expect_out("R6 not armed", 0, 0);
  endtask

  task automatic t_bubbles;
    step(1, C_BRANCH, 32'h0BAD_F00D, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, C_OTHER, 32'h0, 0);
      expect_out("R7 bubble", 0, 0);
    end
    step(1, C_MARKER, 32'h0BAD_F00D, 0); expect_out("R7 wait kept", 0, 1);
  endtask

  task automatic t_flush;
    step(1, C_BRANCH, 32'h0000_1111, 0);
    step(0, C_OTHER, 0, 1);              expect_out("R8 flush", 0, 0);
    step(1, C_OTHER, 32'h0, 0);          expect_out("R8 wait cleared", 0, 0);
    step(1, C_BRANCH, 32'h0000_2222, 0);
    step(1, C_OTHER, 32'h0, 1);          expect_out("R8 same-cycle insn dropped", 0, 0);
    step(1, C_BRANCH, 32'h0000_3333, 1); expect_out("R8 branch dropped", 0, 0);
    step(1, C_OTHER, 32'h0, 0);          expect_out("R8 not armed", 0, 0);
  endtask

  task automatic t_rearm;
    step(1, C_BRANCH, 32'hAAAA_0000, 0);
    step(1, C_BRANCH, 32'hBBBB_0000, 0); expect_out("R9 fence", 1, 0);
    step(1, C_MARKER, 32'hBBBB_0000, 0); expect_out("R9 new label", 0, 1);
    step(1, C_BRANCH, 32'hAAAA_0000, 0);
    step(1, C_BRANCH, 32'hBBBB_0000, 0);
    step(1, C_MARKER, 32'hAAAA_0000, 0); expect_out("R9 old label gone", 1, 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    flush = 0; dec_valid = 0; dec_class = C_OTHER; dec_label = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_match;
    t_mismatch;
    t_other;
    t_idle_marker;
    t_bubbles;
    t_flush;
    t_rearm;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule